// File: doc/BRIEF.md
# Card Clock Divider and Gate

This block makes the serial clock for a memory card from a fixed internal timebase. The timebase `clk` runs at twice the reference frequency. The output therefore toggles every 2^code timebase cycles, and the card clock equals the reference frequency divided by 2^code. A 3-bit code from 0 to 7 gives every division from 1 down to 128.

Software starts and stops the clock by writing command bits to a control port. It selects the division through a separate rate port, and it polls `clkRunning` after a stop request until that bit clears.

The gate acts only at the end of a complete low half-period of the output. The same boundary is used for starting, stopping and changing the rate, so the card never sees a shortened high or low phase. The control write can also carry a command-launch bit alongside the start bit. That bit becomes a one-cycle `cmdLaunch` pulse for the command engine.

Top module: `cardClkGen`

## Requirements
- R1: After reset, `cardClk` is low, `clkRunning` is 0, the rate code is 0, and `cmdLaunch` is 0.
- R2: While running with rate code c (0 to 7), every high phase and every low phase of `cardClk` lasts exactly 2^c `clk` cycles.
- R3: A control write with bit 1 (start) set and bit 0 clear, issued while stopped, sets `clkRunning` on the next edge. `cardClk` then stays low for one full low half-period before it first rises.
- R4: A control write with bit 0 (stop) set, issued while running, is held pending. The output completes its current phases. At the end of the next full low half-period, where the output would have risen, `cardClk` stays low and `clkRunning` falls on that edge.
- R5: A control write with both bit 0 and bit 1 set is treated as a stop. While stopped the clock stays stopped, and while running a stop is scheduled.
- R6: A rate write while running is staged. The new code takes effect at the next end of a low half-period, so the high and low phases already under way keep the old length.
- R7: A start write while running, and a stop write while stopped, have no effect on `cardClk` or `clkRunning`.
- R8: `cmdLaunch` pulses high for one cycle, in the cycle after a control write with bit 2 and bit 1 set and bit 0 clear. Any other control write leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase at twice the reference frequency |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | Control write strobe |
| ctrlData | input | 3 | Control bits: 0 stop, 1 start, 2 launch command |
| rateWr | input | 1 | Rate write strobe |
| rateData | input | RATE_W | Division exponent code |
| cardClk | output | 1 | Gated, divided card clock |
| clkRunning | output | 1 | 1 while the card clock is enabled |
| cmdLaunch | output | 1 | One-cycle command launch pulse |

## Verification
The bench sweeps every rate code and goes after the extremes. At code 0, a design that cannot divide by one would stall or lengthen each phase. At code 7, a short counter would wrap early and produce a fast clock.

It issues stop requests during the high phase and in the middle of the low phase. A gate that cuts the clock at once would leave a runt pulse, or drop the status bit before the low phase had finished.

Rate changes land inside a high phase. A design that switches divisors straight away would shorten or stretch the phase already under way. Simultaneous start and stop checks that the priority is not reversed.

// File: rtl/ccgPkg.sv
package ccgPkg;
  localparam int CTRL_W    = 3;
  localparam int STOP_BIT  = 0;
  localparam int START_BIT = 1;
  localparam int LAUNCH_BIT = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic run;       // divider counts and output may toggle
    logic loadRate;  // take staged rate code into the active one
  } dpStrobe_t;
endpackage

// File: rtl/ccgDiv.sv
module ccgDiv
  import ccgPkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [RATE_W-1:0] rateStage,
  output logic              outClk,
  output logic              lowEnd
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [RATE_W-1:0] rateQ;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  term;
  logic              outReg;

  // terminal count 2^rateQ - 1 as a thermometer mask
  always_comb begin
    for (int i = 0; i < CNT_W; i++) term[i] = (i < int'(rateQ));
  end

  assign lowEnd = !outReg && (cnt == term);
  assign outClk = outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ  <= '0;
      cnt    <= '0;
      outReg <= 1'b0;
    end else begin
      if (strobe.loadRate) rateQ <= rateStage;
      if (!strobe.run) begin
        cnt    <= '0;
        outReg <= 1'b0;
      end else if (cnt == term) begin
        cnt    <= '0;
        outReg <= ~outReg;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R6
  rate_swap_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rateQ) |-> !$past(outReg));

  // R2
  stopped_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strobe.run) |-> (!outReg && cnt == '0));
endmodule

// File: rtl/ccgCtrl.sv
module ccgCtrl
  import ccgPkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              rateWr,
  input  logic [RATE_W-1:0] rateData,
  input  logic              lowEnd,
  output dpStrobe_t         strobe,
  output logic [RATE_W-1:0] rateStage,
  output logic              running,
  output logic              cmdLaunch
);
  logic stopPend;
  logic stopNow;
  logic startReq;
  logic stopReq;

  assign stopReq  = ctrlWr && ctrlData[STOP_BIT];
  assign startReq = ctrlWr && ctrlData[START_BIT] && !ctrlData[STOP_BIT];
  assign stopNow  = running && stopPend && lowEnd;

  assign strobe.run      = running && !stopNow;
  assign strobe.loadRate = !running || lowEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      stopPend  <= 1'b0;
      rateStage <= '0;
      cmdLaunch <= 1'b0;
    end else begin
      cmdLaunch <= startReq && ctrlData[LAUNCH_BIT];
      if (rateWr) rateStage <= rateData;
      if (stopNow) begin
        running  <= 1'b0;
        stopPend <= 1'b0;
      end else if (running) begin
        if (stopReq) stopPend <= 1'b1;
      end else if (startReq) begin
        running <= 1'b1;
      end
    end
  end

  // R4
  pend_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopPend |-> running);

  // R4
  stop_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(lowEnd));

  // R5
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlData[STOP_BIT] && ctrlData[START_BIT] && !running) |=> !running);

  // R8
  launch_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLaunch |-> $past(ctrlWr && ctrlData[LAUNCH_BIT]));
endmodule

// File: rtl/cardClkGen.sv
module cardClkGen
  import ccgPkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [2:0]        ctrlData,
  input  logic              rateWr,
  input  logic [RATE_W-1:0] rateData,
  output logic              cardClk,
  output logic              clkRunning,
  output logic              cmdLaunch
);
  dpStrobe_t         strobe;
  logic [RATE_W-1:0] rateStage;
  logic              lowEnd;

  ccgCtrl #(.RATE_W(RATE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .rateWr(rateWr), .rateData(rateData), .lowEnd(lowEnd),
    .strobe(strobe), .rateStage(rateStage), .running(clkRunning),
    .cmdLaunch(cmdLaunch)
  );

  ccgDiv #(.RATE_W(RATE_W)) uDiv (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rateStage(rateStage),
    .outClk(cardClk), .lowEnd(lowEnd)
  );
endmodule

// File: tb/tb_cardClkGen.sv
module tb_cardClkGen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 1'b0;
  logic [2:0] ctrlData = '0;
  logic       rateWr = 1'b0;
  logic [2:0] rateData = '0;
  logic       cardClk, clkRunning, cmdLaunch;

  int checks = 0;
  int fails = 0;
  string phase = "R1";

  // reference model state
  int  mRun = 0, mPend = 0, mStage = 0, mRate = 0, mOut = 0, mLeft = 1, mLaunch = 0;
  int  mStopped;
  bit  modelValid = 0;

  always #4 clk = ~clk;

  cardClkGen dut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .rateWr(rateWr), .rateData(rateData), .cardClk(cardClk),
    .clkRunning(clkRunning), .cmdLaunch(cmdLaunch)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mPend = 0; mStage = 0; mRate = 0; mOut = 0; mLeft = 1; mLaunch = 0;
    end else begin
      mLaunch = (ctrlWr && ctrlData == 3'b110) ? 1 : 0;
      if (mRun != 0) begin
        mStopped = 0;
        mLeft = mLeft - 1;
        if (mLeft == 0) begin
          if (mOut == 0) begin
            if (mPend != 0) begin
              mRun = 0; mPend = 0; mStopped = 1;
            end else begin
              mRate = mStage; mOut = 1; mLeft = 1 << mRate;
            end
          end else begin
            mOut = 0; mLeft = 1 << mRate;
          end
        end
        if (mStopped == 0 && ctrlWr && ctrlData[0]) mPend = 1;
      end else if (ctrlWr && ctrlData[1] && !ctrlData[0]) begin
        mRun = 1; mOut = 0; mLeft = 1 << mStage;
      end
      if (rateWr) mStage = int'(rateData);
    end
    modelValid = 1;
  end

  task automatic expectEq(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (modelValid) begin
      expectEq(int'(cardClk), mOut, phase, "cardClk");
      expectEq(int'(clkRunning), mRun, phase, "clkRunning");
      expectEq(int'(cmdLaunch), mLaunch, "R8", "cmdLaunch");
    end
  end

  task automatic ctrlWrite(input logic [2:0] d);
    @(negedge clk);
    ctrlWr = 1'b1; ctrlData = d;
    @(negedge clk);
    ctrlWr = 1'b0; ctrlData = '0;
  endtask

  task automatic rateWrite(input int c);
    @(negedge clk);
    rateWr = 1'b1; rateData = 3'(c);
    @(negedge clk);
    rateWr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitStopped(input string req);
    int n = 0;
    while (clkRunning && n < 700) begin
      @(negedge clk);
      n++;
    end
    expectEq(int'(clkRunning), 0, req, "stop completes");
    expectEq(int'(cardClk), 0, req, "low after stop");
  endtask

  // from a rising edge, count high samples over four full periods
  task automatic measureHigh(input int c);
    int n = 0;
    int highs = 0;
    logic prev = cardClk;
    @(negedge clk);
    while (!(cardClk && !prev) && n < 700) begin
      prev = cardClk;
      @(negedge clk);
      n++;
    end
    for (int i = 0; i < (8 << c); i++) begin
      if (cardClk) highs++;
      @(negedge clk);
    end
    expectEq(highs, 4 << c, "R2", "high cycles in four periods");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    expectEq(int'(cardClk), 0, "R1", "reset cardClk");
    expectEq(int'(clkRunning), 0, "R1", "reset status");
    expectEq(int'(cmdLaunch), 0, "R1", "reset launch");
    rstN = 1'b1;
    // rate code 0 after reset: start gives divide-by-one
    phase = "R3";
    ctrlWrite(3'b010);
    expectEq(int'(clkRunning), 1, "R3", "running after start");
    expectEq(int'(cardClk), 0, "R3", "first phase low");
    measureHigh(0);
    phase = "R4";
    ctrlWrite(3'b001);
    waitStopped("R4");

    // sweep every code
    phase = "R2";
    for (int c = 0; c < 8; c++) begin
      rateWrite(c);
      idle(1);
      ctrlWrite(3'b010);
      measureHigh(c);
      ctrlWrite(3'b001);
      waitStopped("R4");
    end

    // stop written during the high phase, code 2
    phase = "R4";
    rateWrite(2);
    idle(1);
    ctrlWrite(3'b010);
    while (!cardClk) @(negedge clk);
    ctrlWrite(3'b001);
    expectEq(int'(clkRunning), 1, "R4", "status held while pending");
    waitStopped("R4");

    // start and stop together
    phase = "R5";
    ctrlWrite(3'b011);
    idle(2);
    expectEq(int'(clkRunning), 0, "R5", "stays stopped");
    ctrlWrite(3'b010);
    idle(5);
    ctrlWrite(3'b011);
    waitStopped("R5");

    // rate change inside a high phase
    phase = "R6";
    rateWrite(1);
    idle(1);
    ctrlWrite(3'b010);
    while (!cardClk) @(negedge clk);
    rateWrite(4);
    idle(80);
    ctrlWrite(3'b001);
    waitStopped("R6");

    // ignored commands
    phase = "R7";
    ctrlWrite(3'b001);
    idle(3);
    expectEq(int'(clkRunning), 0, "R7", "stop while stopped");
    expectEq(int'(cardClk), 0, "R7", "clock idle");
    rateWrite(0);
    idle(1);
    ctrlWrite(3'b010);
    idle(3);
    ctrlWrite(3'b010);
    idle(6);
    expectEq(int'(clkRunning), 1, "R7", "start while running");

    // launch encodings
    phase = "R8";
    @(negedge clk);
    ctrlWr = 1'b1; ctrlData = 3'b110;
    @(negedge clk);
    ctrlWr = 1'b0; ctrlData = '0;
    expectEq(int'(cmdLaunch), 1, "R8", "launch with start");
    @(negedge clk);
    expectEq(int'(cmdLaunch), 0, "R8", "launch one cycle");
    ctrlWrite(3'b100);
    expectEq(int'(cmdLaunch), 0, "R8", "launch alone");
    ctrlWrite(3'b111);
    expectEq(int'(cmdLaunch), 0, "R8", "launch with stop");
    waitStopped("R5");
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule